// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is an I2C target that gives a bus master access to a 2048-byte internal memory. It runs on a fast system clock, oversamples the SCL and SDA lines through two-flop synchronizers and finds START and STOP conditions and SCL edges on the synchronized samples. It pulls SDA low through an open-drain output enable when it acknowledges a byte and when it shifts out a read data bit. At all other times it releases SDA.

The byte address is 11 bits wide. Its upper three bits are the page field of the slave address byte. Its lower eight bits come from a word address byte that follows a write address. The address sits in an internal latch that persists across transactions. Reads send no word address. They start from the page bits of the read address byte combined with the lower byte held in the latch, so a random read is a write preamble followed by a repeated START and a read address.

Each written byte is stored as soon as its last bit arrives. The block therefore never has a busy period, and it acknowledges the next transaction at once. Bursts of any length are supported in both directions, and the address wraps at the top of the memory.

Top module: `i2c_bytemem_target`

## Requirements
- R1: A slave address byte is acknowledged only if its bits 7..4 equal 4'b1010. On a mismatch the block drives no acknowledge and ignores all further bytes, including writes, until the next START.
- R2: In the slave address byte, bits 3..1 give address bits 10..8 (the page) and bit 0 selects the direction (1 = read, 0 = write). Equal word addresses in different pages reach different bytes.
- R3: After an acknowledged write address, the next byte is the word address (address bits 7..0) and is acknowledged. Each following byte is acknowledged and stored at the current address.
- R4: A read address byte starts the read at the location formed by its page bits over the lower 8 bits of the internal address latch.
- R5: The address increments by one after every data byte, whether written or read. It wraps from 7FFh to 000h, and bursts have no length limit.
- R6: A write address plus word address, then a repeated START and a read address, returns data starting at the newly latched address.
- R7: A START or a STOP aborts the transaction in progress. A partially received data byte is not stored, and the block waits for a slave address.
- R8: Read data is sent MSB first. The next byte is sent only if the master drives ACK (SDA low) in the 9th clock. A NACK ends the read and releases SDA.
- R9: SDA is released after reset and whenever the block is neither acknowledging nor sending a read bit. The output enable changes only while SCL is low, except when START or STOP releases it.
- R10: A new transaction that starts right after the STOP of a write is acknowledged. There is no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The assertions assume that SCL and SDA are held stable for several system clocks around every edge. They also assume that the master changes SDA only while SCL is low, apart from START and STOP, so that each synchronized SCL fall is seen well before the next rise. The bench keeps to this by moving each line only after twelve system clocks at a level, and it releases SDA during every 9th clock in which the target answers. The bench also checks on every clock that the target leaves SDA released in each phase where the bus rules forbid it to drive.

// File: rtl/i2c_bytemem_pkg.sv
package i2c_bytemem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_WADDR,
    K_WDATA
  } rx_kind_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_N-1];
      sda_q  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_N-1];
  assign sda_o      = sda_ff[SYNC_N-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // sda edge while scl stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/bytemem_array.sv
module bytemem_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
    rd_o <= mem[ra_i];
  end

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_bytemem_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter logic [14-AW:0] DEV_CODE = 4'b1010
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rdata_i,
  output logic          we_o,
  output logic [AW-1:0] wa_o,
  output logic [7:0]    wd_o,
  output logic [AW-1:0] addr_o,
  output logic          addr_ld_o,
  output logic          sda_oe_o
);

  localparam int unsigned PAGE_W = AW - 8;
  localparam int unsigned DEV_W  = 7 - PAGE_W;

  tgt_state_e    state_q;
  rx_kind_e      kind_q;
  logic          rw_q, mack_q;
  logic [3:0]    bitcnt_q;
  logic [7:0]    shift_q;
  logic [AW-1:0] addr_q;

  logic [7:0] rx_byte;
  logic       rx_done, dev_hit, waddr_ld, tx_done;

  assign rx_byte  = {shift_q[6:0], sda_s_i};
  assign rx_done  = (state_q == ST_RX) && scl_rise_i && (bitcnt_q == 4'd7);
  assign dev_hit  = rx_done && (kind_q == K_DEV) && (rx_byte[7:8-DEV_W] == DEV_CODE);
  assign waddr_ld = rx_done && (kind_q == K_WADDR);
  assign tx_done  = (state_q == ST_TX) && scl_fall_i && (bitcnt_q == 4'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      kind_q   <= K_DEV;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      bitcnt_q <= '0;
      shift_q  <= '0;
    end else if (start_i) begin
      state_q  <= ST_RX;
      kind_q   <= K_DEV;
      bitcnt_q <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise_i && bitcnt_q != 4'd8) begin
            shift_q  <= rx_byte;
            bitcnt_q <= bitcnt_q + 4'd1;
            if (rx_done && kind_q == K_DEV) begin
              if (dev_hit) rw_q <= rx_byte[0];
              else         state_q <= ST_IDLE;
            end
          end else if (scl_fall_i && bitcnt_q == 4'd8) begin
            state_q <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            bitcnt_q <= '0;
            if (kind_q == K_DEV && rw_q) begin
              state_q <= ST_TX;
              shift_q <= rdata_i;
            end else begin
              state_q <= ST_RX;
              if (kind_q == K_DEV) kind_q <= K_WADDR;
              else                 kind_q <= K_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bitcnt_q == 4'd7) begin
              state_q <= ST_RACK;
            end else begin
              shift_q  <= {shift_q[6:0], 1'b0};
              bitcnt_q <= bitcnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_s_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              state_q  <= ST_TX;
              shift_q  <= rdata_i;
              bitcnt_q <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (dev_hit) begin
      addr_q[AW-1:8] <= rx_byte[PAGE_W:1];
    end else if (waddr_ld) begin
      addr_q[7:0] <= rx_byte;
    end else if (we_o || tx_done) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign we_o      = rx_done && (kind_q == K_WDATA);
  assign wa_o      = addr_q;
  assign wd_o      = rx_byte;
  assign addr_o    = addr_q;
  assign addr_ld_o = dev_hit || waddr_ld;
  assign sda_oe_o  = (state_q == ST_ACK) || ((state_q == ST_TX) && !shift_q[7]);

endmodule

// File: rtl/i2c_bytemem_target.sv
module i2c_bytemem_target #(
  parameter int unsigned AW = 11,
  parameter logic [14-AW:0] DEV_CODE = 4'b1010,
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          mem_we, addr_ld;
  logic [AW-1:0] mem_wa, cur_addr;
  logic [7:0]    mem_wd, mem_rd;

  i2c_line_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_tgt_fsm #(.AW(AW), .DEV_CODE(DEV_CODE)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rdata_i    (mem_rd),
    .we_o       (mem_we),
    .wa_o       (mem_wa),
    .wd_o       (mem_wd),
    .addr_o     (cur_addr),
    .addr_ld_o  (addr_ld),
    .sda_oe_o   (sda_oe_o)
  );

  bytemem_array #(.AW(AW), .DW(8)) u_mem (
    .clk_i (clk_i),
    .we_i  (mem_we),
    .wa_i  (mem_wa),
    .wd_i  (mem_wd),
    .ra_i  (cur_addr),
    .rd_o  (mem_rd)
  );

endmodule

// File: rtl/i2c_bytemem_chk.sv
module i2c_bytemem_chk #(
  parameter int unsigned AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s_i,
  input logic          start_i,
  input logic          stop_i,
  input logic          sda_oe_i,
  input logic [AW-1:0] addr_i,
  input logic          addr_ld_i
);

  p_oe_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($changed(sda_oe_i) && scl_s_i) |-> $past(start_i || stop_i));

  p_start_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  p_stop_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(addr_i) |-> ((addr_i == AW'($past(addr_i) + 1'b1)) || $past(addr_ld_i)));

endmodule

bind i2c_bytemem_target i2c_bytemem_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s_i   (scl_s),
  .start_i   (start_det),
  .stop_i    (stop_det),
  .sda_oe_i  (sda_oe_o),
  .addr_i    (cur_addr),
  .addr_ld_i (addr_ld)
);

// File: tb/sim_i2c_bytemem_target.sv
module sim_i2c_bytemem_target;

  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_bytemem_target u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe)
  );

  int checks = 0;
  int fails = 0;
  int viol = 0;
  bit must_release = 1'b0;
  logic [7:0] ref_mem [0:2047];
  int ref_addr = 0;

  // per-clock comparison against the expected release of SDA
  always @(posedge clk) if (must_release && sda_oe) viol++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1;
    wq();
    must_release = 1'b1;
    m_scl = 1'b1;
    wq();
    m_sda = 1'b0;
    wq();
    m_scl = 1'b0;
    must_release = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0;
    wq();
    must_release = 1'b1;
    m_scl = 1'b1;
    wq();
    m_sda = 1'b1;
    wq();
    wq();
    must_release = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    wq();
    must_release = 1'b1;
    m_sda = b;
    wq();
    m_scl = 1'b1;
    wq();
    wq();
    m_scl = 1'b0;
    must_release = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wq();
    m_sda = 1'b1;
    wq();
    m_scl = 1'b1;
    wq();
    ack = ~sda_line;
    wq();
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq();
      m_sda = 1'b1;
      wq();
      m_scl = 1'b1;
      wq();
      b[i] = sda_line;
      wq();
      m_scl = 1'b0;
    end
    send_bit(~mack);
  endtask

  task automatic wr(input logic [2:0] pg, input logic [7:0] wa, input logic [7:0] d[$]);
    logic ack;
    bus_start();
    send_byte({4'b1010, pg, 1'b0}, ack);
    chk("R1 write address ack", int'(ack), 1);
    send_byte(wa, ack);
    chk("R3 word address ack", int'(ack), 1);
    ref_addr = {pg, wa};
    foreach (d[k]) begin
      send_byte(d[k], ack);
      chk("R3 data ack", int'(ack), 1);
      ref_mem[ref_addr] = d[k];
      ref_addr = (ref_addr + 1) % 2048;
    end
    bus_stop();
  endtask

  task automatic rd_cur(input logic [2:0] pg, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({4'b1010, pg, 1'b1}, ack);
    chk("R10 read address ack", int'(ack), 1);
    ref_addr = {pg, ref_addr[7:0]};
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk({tag, " R8 read data"}, int'(b), int'(ref_mem[ref_addr]));
      ref_addr = (ref_addr + 1) % 2048;
    end
    repeat (8) @(negedge clk);
    chk("R8 released after NACK", int'(sda_oe), 0);
    bus_stop();
  endtask

  task automatic rd_rand(input logic [2:0] pg, input logic [7:0] wa, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({4'b1010, pg, 1'b0}, ack);
    chk("R6 preamble address ack", int'(ack), 1);
    send_byte(wa, ack);
    chk("R6 preamble word ack", int'(ack), 1);
    ref_addr = {pg, wa};
    rd_cur(pg, n, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] q[$];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 reset release", int'(sda_oe), 0);

    // byte write then immediate random read (R3, R6, R10)
    wr(3'd2, 8'h10, '{8'h5A});
    rd_rand(3'd2, 8'h10, 1, "R6");

    // burst across the top of memory, then current address read (R5, R4)
    wr(3'd7, 8'hFE, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55});
    rd_rand(3'd7, 8'hFE, 4, "R5 wrap");
    rd_cur(3'd0, 1, "R4");

    // page bits separate locations (R2)
    wr(3'd3, 8'h10, '{8'hC3});
    rd_rand(3'd2, 8'h10, 1, "R2");
    rd_rand(3'd3, 8'h10, 1, "R2");

    // wrong device code ignored until next START (R1)
    bus_start();
    send_byte(8'hB4, ack);
    chk("R1 mismatch no ack", int'(ack), 0);
    send_byte(8'h10, ack);
    chk("R1 ignored word", int'(ack), 0);
    send_byte(8'h99, ack);
    chk("R1 ignored data", int'(ack), 0);
    bus_stop();
    rd_rand(3'd2, 8'h10, 1, "R1 unchanged");

    // partial byte aborted by STOP (R7)
    wr(3'd2, 8'h20, '{8'h77});
    bus_start();
    send_byte(8'hA4, ack);
    chk("R7 address ack", int'(ack), 1);
    send_byte(8'h20, ack);
    chk("R7 word ack", int'(ack), 1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    rd_rand(3'd2, 8'h20, 1, "R7 not stored");

    // write leaves latch after last byte (R5)
    wr(3'd5, 8'h41, '{8'hCD});
    wr(3'd5, 8'h40, '{8'hAB});
    rd_cur(3'd5, 1, "R5 write step");

    // long burst across a page boundary (R5, R8)
    for (int i = 0; i < 20; i++) q.push_back(8'(i * 7 + 3));
    wr(3'd1, 8'hF8, q);
    rd_rand(3'd1, 8'hF8, 20, "R5 burst");

    chk("R9 SDA driven outside ack/read", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule